// File: doc/BRIEF.md
# Serial-Controlled Mixer Gain Register Bank

This block is the digital control core of an eight-input, two-output audio mixer. A host sends 8-bit control words over a slow serial port made of a shift clock, a data line, a write strobe and a load strobe. All of these are sampled in the block's own system clock domain. The top bit of each word says what kind of word it is. An address word picks a channel, and also picks whether the following words set that channel's gain or its output routing. Each gain or routing word then updates the channel picked last. For every channel the block holds a 6-bit attenuation code, a mute flag, and two routing bits (left and right). The analog attenuators and switches downstream read these values.

Two strobe modes are offered. In combined-strobe mode, the write and load pins carry one signal, and a completed word takes effect when write falls. In split-strobe mode, completed words only stage shadow values. A rising edge on load then moves every channel's shadow into the active set at once. Bits leave the far end of the shift register on a data-out pin, so several devices can sit in one serial chain. A system-mute input forces every channel's mute output while it is high, without touching the stored settings.

Top module: `mixctl_top`

## Requirements
- R1: Synchronous reset leaves every channel with attenuation code 63, mute set, both routing bits clear, and data-out low.
- R2: A shift happens only on a rising shift-clock edge seen while write is high. Bits enter LSB-side so the first bit sent ends up as bit 7 (MSB first). Data-out shows the current bit 7 of the shift register, so a bit reappears on data-out after eight more shifts.
- R3: When write falls and the word has bit 7 = 1, it is an address word: bits [2:0] select channel 0..7 (attenuation field i sits at atten_o[6i+5:6i]), and bit 3 = 1 selects the routing target instead of the gain target. An address word changes no channel output.
- R4: A gain word (bit 7 = 0, gain target) writes bits [5:0] as the channel's attenuation code. Mute is set when bit 6 is 1 or the code is 63, and cleared otherwise.
- R5: A routing word (bit 7 = 0, routing target) sets the channel's left routing from bit 0 and its right routing from bit 1.
- R6: With mode_3w low, gain and routing words change no output until a rising edge of load. That edge updates all channels together.
- R7: With mode_3w high, a gain or routing word reaches the outputs one system clock after write falls, and load has no separate role.
- R8: While sys_mute is high, every bit of mute_o is 1 and attenuation and routing outputs are unchanged. Releasing it restores the stored mute flags.
- R9: The selected channel and target persist across any number of data words until the next address word.
- R10: Shift-clock edges while write is low leave the shift register, and so data-out, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_3w | input | 1 | 1 = combined strobe, 0 = split write/load |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data in |
| wr | input | 1 | Write strobe, active high |
| ld | input | 1 | Load strobe, rising edge commits (split mode) |
| sys_mute | input | 1 | Global mute override |
| atten_o | output | 48 | Attenuation codes, 6 bits per channel |
| mute_o | output | 8 | Per-channel mute |
| route_l_o | output | 8 | Per-channel left routing |
| route_r_o | output | 8 | Per-channel right routing |
| dout | output | 1 | Serial data out for chaining |

## Verification
A wrong channel select or a stale target flag shows up as the wrong channel's attenuation or routing field changing. It can also show as a gain value landing in the routing bits, visible one system clock after write falls in combined mode. In split mode, a faulty staging path shows either as outputs that move before load or as channels that fail to move together on the load edge. A shift-register fault shows on data-out within the eight shifts that bring the bad bit to the far end.

// File: rtl/mixctl_pkg.sv
package mixctl_pkg;
    localparam int WORD_W = 8;
    localparam int ATT_W  = 6;

    typedef struct packed {
        logic             mute;
        logic [ATT_W-1:0] att;
        logic             rl;
        logic             rr;
    } chan_t;

    localparam chan_t CHAN_RST = '{mute: 1'b1, att: {ATT_W{1'b1}}, rl: 1'b0, rr: 1'b0};

    function automatic logic gain_mutes(input logic [WORD_W-1:0] w);
        return w[6] | (&w[ATT_W-1:0]);
    endfunction
endpackage

// File: rtl/mixctl_shift.sv
module mixctl_shift
    import mixctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              wr,
    input  logic              ld,
    output logic [WORD_W-1:0] word,
    output logic              word_done,
    output logic              ld_pulse,
    output logic              dout
);
    logic              sclk_q, wr_q, ld_q;
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            wr_q   <= 1'b0;
            ld_q   <= 1'b0;
            sh     <= '0;
        end else begin
            sclk_q <= ser_clk;
            wr_q   <= wr;
            ld_q   <= ld;
            if (wr && ser_clk && !sclk_q)
                sh <= {sh[WORD_W-2:0], ser_dat};
        end
    end

    assign word      = sh;
    assign word_done = wr_q & ~wr;
    assign ld_pulse  = ld & ~ld_q;
    assign dout      = sh[WORD_W-1];
endmodule

// File: rtl/mixctl_decode.sv
module mixctl_decode
    import mixctl_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  logic              word_done,
    output logic              gain_we,
    output logic              route_we,
    output logic [CH_W-1:0]   sel_ch
);
    logic sel_route;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_ch    <= '0;
            sel_route <= 1'b0;
        end else if (word_done && word[WORD_W-1]) begin
            sel_ch    <= word[CH_W-1:0];
            sel_route <= word[3];
        end
    end

    assign gain_we  = word_done & ~word[WORD_W-1] & ~sel_route;
    assign route_we = word_done & ~word[WORD_W-1] &  sel_route;
endmodule

// File: rtl/mixctl_bank.sv
module mixctl_bank
    import mixctl_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_3w,
    input  logic                gain_we,
    input  logic                route_we,
    input  logic [CH_W-1:0]     sel_ch,
    input  logic [WORD_W-1:0]   word,
    input  logic                ld_pulse,
    output chan_t [NCH-1:0]     act
);
    chan_t [NCH-1:0] shd, shd_nxt;
    logic            commit;

    always_comb begin
        shd_nxt = shd;
        if (gain_we) begin
            shd_nxt[sel_ch].att  = word[ATT_W-1:0];
            shd_nxt[sel_ch].mute = gain_mutes(word);
        end
        if (route_we) begin
            shd_nxt[sel_ch].rl = word[0];
            shd_nxt[sel_ch].rr = word[1];
        end
    end

    assign commit = mode_3w ? (gain_we | route_we) : ld_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= {NCH{CHAN_RST}};
            act <= {NCH{CHAN_RST}};
        end else begin
            shd <= shd_nxt;
            if (commit)
                act <= shd_nxt;
        end
    end
endmodule

// File: rtl/mixctl_top.sv
module mixctl_top
    import mixctl_pkg::*;
#(
    parameter int NCH  = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_3w,
    input  logic               ser_clk,
    input  logic               ser_dat,
    input  logic               wr,
    input  logic               ld,
    input  logic               sys_mute,
    output logic [NCH*ATT_W-1:0] atten_o,
    output logic [NCH-1:0]     mute_o,
    output logic [NCH-1:0]     route_l_o,
    output logic [NCH-1:0]     route_r_o,
    output logic               dout
);
    logic [WORD_W-1:0] word;
    logic              word_done, ld_pulse, gain_we, route_we;
    logic [CH_W-1:0]   sel_ch;
    chan_t [NCH-1:0]   act;

    mixctl_shift u_shift (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .wr(wr), .ld(ld),
        .word(word), .word_done(word_done), .ld_pulse(ld_pulse), .dout(dout)
    );

    mixctl_decode #(.NCH(NCH)) u_dec (
        .clk(clk), .rst(rst), .word(word), .word_done(word_done),
        .gain_we(gain_we), .route_we(route_we), .sel_ch(sel_ch)
    );

    mixctl_bank #(.NCH(NCH)) u_bank (
        .clk(clk), .rst(rst), .mode_3w(mode_3w), .gain_we(gain_we), .route_we(route_we),
        .sel_ch(sel_ch), .word(word), .ld_pulse(ld_pulse), .act(act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_out
        assign atten_o[i*ATT_W +: ATT_W] = act[i].att;
        assign mute_o[i]    = act[i].mute | sys_mute;
        assign route_l_o[i] = act[i].rl;
        assign route_r_o[i] = act[i].rr;
    end
endmodule

// File: rtl/mixctl_chk.sv
module mixctl_chk
    import mixctl_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mode_3w,
    input logic                 ser_clk,
    input logic                 wr,
    input logic                 ld,
    input logic                 sys_mute,
    input logic [NCH*ATT_W-1:0] atten_o,
    input logic [NCH-1:0]       mute_o,
    input logic [NCH-1:0]       route_l_o,
    input logic [NCH-1:0]       route_r_o,
    input logic                 dout,
    input logic [WORD_W-1:0]    word,
    input logic                 word_done
);
    logic past_valid = 1'b0;
    logic sclk_prev  = 1'b0;
    always_ff @(posedge clk) begin
        past_valid <= 1'b1;
        sclk_prev  <= ser_clk;
    end

    AST_RESET_MUTED: assert property (@(posedge clk)
        (past_valid && $past(rst)) |-> (mute_o == '1 && route_l_o == '0 && route_r_o == '0)); // R1

    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !(wr && ser_clk && !sclk_prev)) |=> $stable(dout)); // R10

    AST_ADDR_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (word_done && word[WORD_W-1]) |=> ($stable(atten_o) && $stable(route_l_o) && $stable(route_r_o))); // R3

    AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mode_3w && !ld) |=> ($stable(atten_o) && $stable(route_l_o) && $stable(route_r_o))); // R6

    AST_SYS_MUTE_ALL: assert property (@(posedge clk) disable iff (rst)
        sys_mute |-> (mute_o == '1)); // R8

    for (genvar i = 0; i < NCH; i++) begin : g_m
        AST_CODE63_MUTED: assert property (@(posedge clk) disable iff (rst)
            (past_valid && (&atten_o[i*ATT_W +: ATT_W])) |-> mute_o[i]); // R4
    end
endmodule

bind mixctl_top mixctl_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .mode_3w(mode_3w), .ser_clk(ser_clk), .wr(wr), .ld(ld),
    .sys_mute(sys_mute), .atten_o(atten_o), .mute_o(mute_o), .route_l_o(route_l_o),
    .route_r_o(route_r_o), .dout(dout), .word(word), .word_done(word_done)
);

// File: tb/test_mixctl_top.sv
module test_mixctl_top;
    logic clk = 1'b0;
    logic rst = 1'b1, mode_3w = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
    logic wr = 1'b0, ld = 1'b0, sys_mute = 1'b0;
    logic [47:0] atten_o;
    logic [7:0]  mute_o, route_l_o, route_r_o;
    logic        dout;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    mixctl_top i_mixctl_top (
        .clk(clk), .rst(rst), .mode_3w(mode_3w), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .wr(wr), .ld(ld), .sys_mute(sys_mute), .atten_o(atten_o), .mute_o(mute_o),
        .route_l_o(route_l_o), .route_r_o(route_r_o), .dout(dout)
    );

    task automatic wait2();
        repeat (2) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int att(input int ch);
        return int'(atten_o[ch*6 +: 6]);
    endfunction

    task automatic shift_bits(input logic [7:0] b);
        for (int k = 7; k >= 0; k--) begin
            ser_dat = b[k]; wait2();
            ser_clk = 1'b1; wait2();
            ser_clk = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        wr = 1'b1; wait2();
        shift_bits(b);
        wait2();
        wr = 1'b0; wait2();
    endtask

    task automatic pulse_ld();
        ld = 1'b1; wait2();
        ld = 1'b0; wait2();
    endtask

    task automatic t_reset();
        check("R1 mute", mute_o, 8'hFF);
        check("R1 att ch0", att(0), 63);
        check("R1 att ch7", att(7), 63);
        check("R1 route", {route_l_o, route_r_o}, 0);
        check("R1 dout", dout, 0);
    endtask

    task automatic t_gain3w();
        mode_3w = 1'b1;
        send(8'h82);
        check("R3 addr no change", att(2), 63);
        send(8'h14);
        check("R7 R4 att ch2", att(2), 20);
        check("R4 unmute ch2", mute_o[2], 0);
        send(8'h05);
        check("R9 persist ch2", att(2), 5);
        check("R9 ch3 untouched", att(3), 63);
    endtask

    task automatic t_route();
        send(8'h8A);
        send(8'h03);
        check("R5 both", {route_l_o[2], route_r_o[2]}, 3);
        check("R5 att kept", att(2), 5);
        send(8'h02);
        check("R5 right only", {route_l_o[2], route_r_o[2]}, 1);
        check("R5 other ch", {route_l_o, route_r_o} & 16'hFBFB, 0);
    endtask

    task automatic t_mute();
        send(8'h85);
        send(8'h0A);
        check("R4 code10", {mute_o[5], 6'(att(5))}, {1'b0, 6'd10});
        send(8'h3F);
        check("R4 code63 mutes", {mute_o[5], 6'(att(5))}, {1'b1, 6'd63});
        send(8'h4A);
        check("R4 bit6 mutes", {mute_o[5], 6'(att(5))}, {1'b1, 6'd10});
        send(8'h87);
        check("R3 addr only ch7", {mute_o[7], 6'(att(7))}, {1'b1, 6'd63});
    endtask

    task automatic t_split();
        mode_3w = 1'b0;
        send(8'h80);
        send(8'h21);
        send(8'h81);
        send(8'h02);
        check("R6 hold ch0", {mute_o[0], 6'(att(0))}, {1'b1, 6'd63});
        check("R6 hold ch1", {mute_o[1], 6'(att(1))}, {1'b1, 6'd63});
        pulse_ld();
        check("R6 load ch0", {mute_o[0], 6'(att(0))}, {1'b0, 6'd33});
        check("R6 load ch1", {mute_o[1], 6'(att(1))}, {1'b0, 6'd2});
    endtask

    task automatic t_sysmute();
        sys_mute = 1'b1; wait2();
        check("R8 all muted", mute_o, 8'hFF);
        check("R8 att kept", att(0), 33);
        sys_mute = 1'b0; wait2();
        check("R8 restore ch0", mute_o[0], 0);
        check("R8 restore ch5", mute_o[5], 1);
    endtask

    task automatic t_gate();
        check("R10 dout pre", dout, 0);
        shift_bits(8'hFF);
        check("R10 dout no shift", dout, 0);
    endtask

    task automatic t_chain();
        logic [7:0] a;
        a = 8'hA5;
        wr = 1'b1; wait2();
        shift_bits(a);
        check("R2 dout msb", dout, a[7]);
        for (int k = 1; k <= 7; k++) begin
            ser_dat = 1'b1; wait2();
            ser_clk = 1'b1; wait2();
            ser_clk = 1'b0;
            check("R2 chain bit", dout, a[7-k]);
        end
        ser_dat = 1'b0; wait2();
        ser_clk = 1'b1; wait2();
        ser_clk = 1'b0; wait2();
        wr = 1'b0; wait2();
        check("R2 tail addr no change", att(0), 33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; wait2();
        t_reset();
        t_gain3w();
        t_route();
        t_mute();
        t_split();
        t_sysmute();
        t_gate();
        t_chain();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule